// File: doc/BRIEF.md
# Interrupt Source State Bank

This block holds the per-source state of a 32-input interrupt controller. For every source it keeps a pending flag, an enable-mask flag, a fast-forcing flag and a mode word. The mode word carries a 3-bit priority and a trigger-type bit. The block feeds these vectors to a separate priority arbiter. Raw request lines are registered once per clock, and the pending flags are updated from the registered value. Level sources track their line. Edge sources hold their flag until software or the consumer clears it.

Software reaches the state through a simple word-addressed port. Writes use `wrEn`, `addr` and `wrData`. Reads are combinational on `addr` and appear on `rdData`. Command addresses set or clear bits in the mask, pending and fast-force vectors, and they read back as zero. Polarity inversion, vector storage and arbitration belong to other blocks.

Top module: `intr_src_bank`

## Requirements
- R1: After reset, the pending, mask and fast-force vectors are all zero, every mode word reads zero, and `prioOut` and `edgeOut` are zero.
- R2: A write to byte address 0x000+4*i sets source i's mode word. Bits 2:0 are the priority and bit 5 is the trigger type (1 = edge, 0 = level). Reading that address returns only those bits, with all other bits zero. `prioOut[3i+2:3i]` and `edgeOut[i]` show the stored values.
- R3: A request line that is high before clock edge k has set that source's pending bit after edge k+1. One register samples the line and a second register holds the pending bit.
- R4: A low line clears the pending bit of a level source with the same two-edge latency. An edge source's pending bit stays set after its line falls.
- R5: Writing 0x120 ORs the written value into the mask vector.
- R6: Writing 0x124 clears every mask bit that is set in the written value.
- R7: Writing 0x128 clears the pending bits selected by the value, but only for edge sources. Selected bits of level sources keep following their line.
- R8: Writing 0x12C sets the pending bits selected by the value, but only for edge sources. Selected bits of level sources are ignored.
- R9: When a clear-pending write and a sampled high line for the same edge source meet in one cycle, the line wins and the pending bit ends up set.
- R10: Writing 0x140 ORs bits into the fast-force vector and writing 0x144 clears them. The vector reads back at 0x148 and drives `fastOut`.
- R11: The pending vector reads at 0x10C and the mask vector at 0x110. Command addresses and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqLines | input | 32 | Raw interrupt request lines |
| wrEn | input | 1 | Write strobe |
| addr | input | 9 | Byte address (word aligned) |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| pendOut | output | 32 | Pending vector |
| maskOut | output | 32 | Enable-mask vector |
| fastOut | output | 32 | Fast-force vector |
| prioOut | output | 96 | Packed 3-bit priorities, source i at [3i+2:3i] |
| edgeOut | output | 32 | Trigger type per source, 1 = edge |
| lineQ | output | 32 | Registered request lines |

## Verification
In one cycle, a software clear-pending command and a registered request line can act on the same edge-triggered source. The bench provokes this by raising the line one cycle before the clear write. The write is then presented in exactly the cycle in which the sampled line is high, and the line drops in that same cycle. The result is judged on `pendOut` one edge later: the bit must be set, so the line has taken precedence over the command. The same overlap is also stated as a clocked property over the registered line and the pending output.

// File: rtl/intr_src_pkg.sv
package intr_src_pkg;
  localparam int NUM_SRC  = 32;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 9;
  localparam int PRIO_W   = 3;
  localparam int EDGE_BIT = 5;
  localparam int IDX_W    = $clog2(NUM_SRC);

  localparam logic [ADDR_W-1:0] A_PEND     = 9'h10C;
  localparam logic [ADDR_W-1:0] A_MASK     = 9'h110;
  localparam logic [ADDR_W-1:0] A_MASK_SET = 9'h120;
  localparam logic [ADDR_W-1:0] A_MASK_CLR = 9'h124;
  localparam logic [ADDR_W-1:0] A_PEND_CLR = 9'h128;
  localparam logic [ADDR_W-1:0] A_PEND_SET = 9'h12C;
  localparam logic [ADDR_W-1:0] A_FAST_SET = 9'h140;
  localparam logic [ADDR_W-1:0] A_FAST_CLR = 9'h144;
  localparam logic [ADDR_W-1:0] A_FAST     = 9'h148;

  typedef enum logic [2:0] {
    RD_NONE, RD_MODE, RD_PEND, RD_MASK, RD_FAST
  } rdSel_e;

  typedef struct packed {
    logic             modeWr;
    logic [IDX_W-1:0] idx;
    logic             maskSet;
    logic             maskClr;
    logic             pendClr;
    logic             pendSet;
    logic             fastSet;
    logic             fastClr;
  } cmdStrobe_t;
endpackage

// File: rtl/intr_src_ctrl.sv
module intr_src_ctrl
  import intr_src_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int AW    = ADDR_W
) (
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  output cmdStrobe_t    stb,
  output rdSel_e        rdSel
);
  localparam int REGION_LSB = IDX_W + 2;

  logic inModeRegion;
  logic [IDX_W-1:0] wordIdx;

  assign wordIdx = addr[IDX_W+1:2];
  // Mode words sit in the first N_SRC aligned words.
  assign inModeRegion = (addr[AW-1:REGION_LSB] == '0) && (addr[1:0] == 2'b00)
                        && (int'(wordIdx) < N_SRC);

  always_comb begin
    stb         = '0;
    stb.idx     = wordIdx;
    stb.modeWr  = wrEn && inModeRegion;
    stb.maskSet = wrEn && (addr == A_MASK_SET);
    stb.maskClr = wrEn && (addr == A_MASK_CLR);
    stb.pendClr = wrEn && (addr == A_PEND_CLR);
    stb.pendSet = wrEn && (addr == A_PEND_SET);
    stb.fastSet = wrEn && (addr == A_FAST_SET);
    stb.fastClr = wrEn && (addr == A_FAST_CLR);
  end

  always_comb begin
    if (inModeRegion)        rdSel = RD_MODE;
    else if (addr == A_PEND) rdSel = RD_PEND;
    else if (addr == A_MASK) rdSel = RD_MASK;
    else if (addr == A_FAST) rdSel = RD_FAST;
    else                     rdSel = RD_NONE;
  end
endmodule

// File: rtl/intr_src_dp.sv
module intr_src_dp
  import intr_src_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int DW    = DATA_W,
  parameter int PW    = PRIO_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_SRC-1:0]  irqLines,
  input  logic [DW-1:0]     wrData,
  input  cmdStrobe_t        stb,
  input  rdSel_e            rdSel,
  output logic [DW-1:0]     rdData,
  output logic [N_SRC-1:0]  pendOut,
  output logic [N_SRC-1:0]  maskOut,
  output logic [N_SRC-1:0]  fastOut,
  output logic [N_SRC*PW-1:0] prioOut,
  output logic [N_SRC-1:0]  edgeOut,
  output logic [N_SRC-1:0]  lineQ
);
  logic [N_SRC-1:0] pendQ, maskQ, fastQ, edgeQ, pendNxt;
  logic [PW-1:0]    prioQ [N_SRC];
  logic [N_SRC-1:0] cmdBits;

  assign cmdBits = wrData[N_SRC-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) lineQ <= '0;
    else       lineQ <= irqLines;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic nxtBit;
    always_comb begin
      nxtBit = pendQ[i];
      if (stb.pendClr && edgeQ[i] && cmdBits[i]) nxtBit = 1'b0;
      if (stb.pendSet && edgeQ[i] && cmdBits[i]) nxtBit = 1'b1;
      // The sampled line is applied last, so a set from the line overrides a command.
      if (lineQ[i])       nxtBit = 1'b1;
      else if (!edgeQ[i]) nxtBit = 1'b0;
    end
    assign pendNxt[i] = nxtBit;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        prioQ[i] <= '0;
        edgeQ[i] <= 1'b0;
      end else if (stb.modeWr && (int'(stb.idx) == i)) begin
        prioQ[i] <= wrData[PW-1:0];
        edgeQ[i] <= wrData[EDGE_BIT];
      end
    end

    assign prioOut[i*PW +: PW] = prioQ[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      maskQ <= '0;
      fastQ <= '0;
    end else begin
      pendQ <= pendNxt;
      if (stb.maskSet)      maskQ <= maskQ | cmdBits;
      else if (stb.maskClr) maskQ <= maskQ & ~cmdBits;
      if (stb.fastSet)      fastQ <= fastQ | cmdBits;
      else if (stb.fastClr) fastQ <= fastQ & ~cmdBits;
    end
  end

  always_comb begin
    rdData = '0;
    unique case (rdSel)
      RD_MODE: begin
        rdData[PW-1:0]   = prioQ[stb.idx];
        rdData[EDGE_BIT] = edgeQ[stb.idx];
      end
      RD_PEND: rdData[N_SRC-1:0] = pendQ;
      RD_MASK: rdData[N_SRC-1:0] = maskQ;
      RD_FAST: rdData[N_SRC-1:0] = fastQ;
      default: rdData = '0;
    endcase
  end

  assign pendOut = pendQ;
  assign maskOut = maskQ;
  assign fastOut = fastQ;
  assign edgeOut = edgeQ;
endmodule

// File: rtl/intr_src_bank.sv
module intr_src_bank
  import intr_src_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_SRC-1:0]    irqLines,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  output logic [NUM_SRC-1:0]    pendOut,
  output logic [NUM_SRC-1:0]    maskOut,
  output logic [NUM_SRC-1:0]    fastOut,
  output logic [NUM_SRC*PRIO_W-1:0] prioOut,
  output logic [NUM_SRC-1:0]    edgeOut,
  output logic [NUM_SRC-1:0]    lineQ
);
  cmdStrobe_t stb;
  rdSel_e     rdSel;

  intr_src_ctrl #(.N_SRC(NUM_SRC), .AW(ADDR_W)) u_ctrl (
    .wrEn (wrEn),
    .addr (addr),
    .stb  (stb),
    .rdSel(rdSel)
  );

  intr_src_dp #(.N_SRC(NUM_SRC), .DW(DATA_W), .PW(PRIO_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .irqLines(irqLines),
    .wrData  (wrData),
    .stb     (stb),
    .rdSel   (rdSel),
    .rdData  (rdData),
    .pendOut (pendOut),
    .maskOut (maskOut),
    .fastOut (fastOut),
    .prioOut (prioOut),
    .edgeOut (edgeOut),
    .lineQ   (lineQ)
  );
endmodule

// File: rtl/intr_src_chk.sv
module intr_src_chk
  import intr_src_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    wrData,
  input logic [DATA_W-1:0]    rdData,
  input logic [NUM_SRC-1:0]   lineQ,
  input logic [NUM_SRC-1:0]   pendOut,
  input logic [NUM_SRC-1:0]   maskOut,
  input logic [NUM_SRC-1:0]   fastOut,
  input logic [NUM_SRC-1:0]   edgeOut
);
  // R3 R9
  line_sets_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(lineQ) & ~pendOut) == '0));

  // R4
  level_follows_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(~lineQ & ~edgeOut) & pendOut) == '0));

  // R5
  mask_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_MASK_SET) |=> ((maskOut & $past(wrData)) == $past(wrData)));

  // R6
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_MASK_CLR) |=> ((maskOut & $past(wrData)) == '0));

  // R7
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_PEND_CLR) |=> ((pendOut & $past(wrData & edgeOut & ~lineQ)) == '0));

  // R8
  pend_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_PEND_SET) |=>
      ((pendOut & $past(wrData & edgeOut)) == $past(wrData & edgeOut)));

  // R10
  fast_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_FAST_SET) |=> ((fastOut & $past(wrData)) == $past(wrData)));

  // R11
  cmd_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addr == A_MASK_SET || addr == A_PEND_CLR) |-> (rdData == '0));
endmodule

bind intr_src_bank intr_src_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .addr   (addr),
  .wrData (wrData),
  .rdData (rdData),
  .lineQ  (lineQ),
  .pendOut(pendOut),
  .maskOut(maskOut),
  .fastOut(fastOut),
  .edgeOut(edgeOut)
);

// File: tb/test_intr_src_bank.sv
module test_intr_src_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] irqLines;
  logic        wrEn;
  logic [8:0]  addr;
  logic [31:0] wrData;
  logic [31:0] rdData, pendOut, maskOut, fastOut, edgeOut, lineQ;
  logic [95:0] prioOut;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_src_bank i_intr_src_bank (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pendOut(pendOut), .maskOut(maskOut),
    .fastOut(fastOut), .prioOut(prioOut), .edgeOut(edgeOut), .lineQ(lineQ)
  );

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; addr = 9'h1FC; wrData = '0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
    addr = 9'h1FC;
  endtask

  task automatic waitN(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 pend", pendOut, 0);
    check("R1 mask", maskOut, 0);
    check("R1 fast", fastOut, 0);
    check("R1 prio", prioOut, 0);
    rd(9'h00C, d);
    check("R1 mode", d, 0);
  endtask

  task automatic t_mode();
    logic [31:0] d;
    wr(9'h00C, 32'hFFFF_FFFF);
    rd(9'h00C, d);
    check("R2 mode readback", d, 32'h27);
    check("R2 prio field", prioOut[11:9], 3'd7);
    check("R2 edge bit", edgeOut, 32'h8);
    wr(9'h000, 32'h5);
    rd(9'h000, d);
    check("R2 level mode", d, 32'h5);
    check("R2 prio src0", prioOut[2:0], 3'd5);
  endtask

  task automatic t_level();
    @(negedge clk); irqLines[1] = 1'b1;
    waitN(1);
    check("R3 one edge not yet", pendOut[1], 1'b0);
    waitN(1);
    check("R3 line sets pend", pendOut[1], 1'b1);
    irqLines[1] = 1'b0;
    waitN(2);
    check("R4 level clears", pendOut[1], 1'b0);
  endtask

  task automatic t_edge();
    @(negedge clk); irqLines[3] = 1'b1;
    @(negedge clk); irqLines[3] = 1'b0;
    waitN(3);
    check("R4 edge stays", pendOut[3], 1'b1);
  endtask

  task automatic t_mask();
    wr(9'h120, 32'h0000_00F0);
    wr(9'h120, 32'h0000_000F);
    check("R5 enable OR", maskOut, 32'hFF);
    wr(9'h124, 32'h0000_003C);
    check("R6 disable clears", maskOut, 32'hC3);
  endtask

  task automatic t_clrset();
    @(negedge clk); irqLines[1] = 1'b1;
    waitN(2);
    wr(9'h128, 32'hFFFF_FFFF);
    check("R7 clear edge only", pendOut, 32'h2);
    wr(9'h12C, 32'hFFFF_FFFF);
    check("R8 set edge only", pendOut, 32'hA);
    irqLines[1] = 1'b0;
    waitN(2);
    wr(9'h12C, 32'h0000_0002);
    check("R8 level set ignored", pendOut, 32'h8);
  endtask

  task automatic t_race();
    wr(9'h128, 32'h8);
    check("R7 edge cleared", pendOut[3], 1'b0);
    @(negedge clk); irqLines[3] = 1'b1;
    @(negedge clk);
    irqLines[3] = 1'b0;
    wrEn = 1'b1; addr = 9'h128; wrData = 32'h8;
    @(negedge clk);
    wrEn = 1'b0; addr = 9'h1FC; wrData = '0;
    check("R9 line beats clear", pendOut[3], 1'b1);
  endtask

  task automatic t_fast();
    logic [31:0] d;
    wr(9'h140, 32'hA5);
    wr(9'h144, 32'h05);
    check("R10 fastOut", fastOut, 32'hA0);
    rd(9'h148, d);
    check("R10 fast read", d, 32'hA0);
  endtask

  task automatic t_read();
    logic [31:0] d;
    rd(9'h10C, d);
    check("R11 pend read", d, 32'h8);
    rd(9'h110, d);
    check("R11 mask read", d, 32'hC3);
    rd(9'h120, d);
    check("R11 cmd reads zero", d, 0);
    rd(9'h1FC, d);
    check("R11 unmapped zero", d, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; irqLines = '0; wrEn = 1'b0; addr = 9'h1FC; wrData = '0;
    waitN(3);
    rstN = 1'b1;
    waitN(1);
    t_reset();
    t_mode();
    t_level();
    t_edge();
    t_mask();
    t_clrset();
    t_race();
    t_fast();
    t_read();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule